// File: doc/BRIEF.md
# Mode Register Programming Controller

This block sits inside a DDR2 memory controller and owns the contents of the base mode register. Each time the command path issues a LOAD MODE, it presents the mode word together with a one-cycle load strobe. The block checks the word and refuses it if any field holds a reserved code. A word it accepts is decoded into burst length, burst ordering, CAS latency, write recovery and active power-down exit speed. Those fields are held on dedicated outputs for the scheduler and the datapath.

Two bits in the word are handled specially. The test-mode bit is never taken as a configuration: the block records that test mode was requested, reports an error, and leaves every field as it was. The DLL-reset bit acts only once. It produces a single pulse and is never stored, so the read-back word always shows it as zero. It also starts a read lockout lasting a parameterised number of clocks (200 by default). During the lockout, READ requests from the scheduler are refused and reported as violations.

Top module: `modecfg_ctrl`

## Requirements
- R1: After reset the fields are BL4 (`bl8_o`=0), sequential order (`interleave_o`=0), `cas_lat_o`=3, `wr_rec_o`=2, fast power-down exit (`slow_pd_o`=0), `test_mode_o`=0, `rd_ok_o`=1, and `cfg_word_o`=0x0232.
- R2: A valid normal load updates the fields on the clock edge at which it is taken. The word fields are: bits[2:0] burst length (010 = BL4, 011 = BL8), bit 3 burst order (1 = interleaved), bits[6:4] CAS latency (011..110 = 3..6), bits[11:9] write recovery (001..101 = 2..6).
- R3: A normal load (bit 7 = 0) with a reserved burst-length, CAS or write-recovery code pulses `cfg_err_o` for one cycle. It changes no field and no read-back bit, and it starts no DLL reset even when bit 8 is set.
- R4: A load with bit 7 = 1 sets `test_mode_o` and pulses `cfg_err_o`, and it updates no other field. The next valid normal load clears `test_mode_o`.
- R5: A valid load with bit 8 = 1 gives a one-cycle `dll_rst_o` pulse, and `cfg_word_o` bit 8 reads back as 0.
- R6: After a DLL-reset load, `rd_ok_o` is low for exactly LOCK_CYCLES clocks (200 by default) and then goes high.
- R7: While `rd_ok_o` is low, a READ request gets no `rd_grant_o`, and `rd_viol_o` pulses on the next cycle. While `rd_ok_o` is high, `rd_grant_o` follows `rd_req_i` and no violation is raised.
- R8: A second DLL-reset load during a lockout restarts the full LOCK_CYCLES count.
- R9: A READ request in the same cycle as a DLL-reset load is judged on the lockout state before that load.
- R10: Bit 12 selects the power-down exit speed: 0 = fast (`slow_pd_o`=0), 1 = slow (`slow_pd_o`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | LOAD MODE strobe |
| word_i | input | WORD_W | Mode word |
| rd_req_i | input | 1 | READ request from scheduler |
| rd_grant_o | output | 1 | READ accepted this cycle |
| rd_ok_o | output | 1 | Reads permitted (no lockout) |
| rd_viol_o | output | 1 | Pulse: previous cycle's READ was blocked |
| bl8_o | output | 1 | Burst length 8 (0 = 4) |
| interleave_o | output | 1 | Interleaved burst ordering |
| cas_lat_o | output | 3 | CAS latency in clocks |
| wr_rec_o | output | 3 | Write recovery in clocks |
| slow_pd_o | output | 1 | Slow-exit active power-down |
| test_mode_o | output | 1 | Test mode was requested |
| dll_rst_o | output | 1 | DLL reset pulse |
| cfg_err_o | output | 1 | Pulse: load rejected |
| cfg_word_o | output | WORD_W | Accepted word, DLL bit cleared |

## Verification
A DLL-reset load and a READ request can arrive in the same cycle. The two collide at the lockout counter: the load reloads it, while the read is judged against its current value. The bench raises both strobes on one falling edge while reads are permitted. It expects the grant to be high in that cycle, no violation on the following cycle, and the lockout visible only after the edge. A second case repeats the collision in the middle of a lockout. There the read must be refused and the count must restart from the full value.

// File: rtl/modecfg_pkg.sv
// Package: shared field layout and decoded configuration type for the
// mode register controller. Assumes a mode word of at least 13 bits.
package modecfg_pkg;

    localparam int BL_LSB   = 0;
    localparam int BT_BIT   = 3;
    localparam int CL_LSB   = 4;
    localparam int TM_BIT   = 7;
    localparam int DLL_BIT  = 8;
    localparam int WR_LSB   = 9;
    localparam int PD_BIT   = 12;

    typedef struct packed {
        logic       bl8;
        logic       interleave;
        logic [2:0] cas;
        logic [2:0] wrec;
        logic       slow_pd;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{bl8: 1'b0, interleave: 1'b0,
                                        cas: 3'd3, wrec: 3'd2, slow_pd: 1'b0};

endpackage

// File: rtl/modecfg_decode.sv
// Module: modecfg_decode
// Purely combinational check and decode of one mode word. It flags a test
// request, a reserved field code, and a DLL reset request. It assumes the
// caller qualifies every output with the load strobe.
module modecfg_decode
    import modecfg_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic [WORD_W-1:0] word_i,
    output mode_cfg_t         cfg_o,
    output logic              is_test_o,
    output logic              valid_o,
    output logic              dll_req_o
);

    logic [2:0] bl_code;
    logic [2:0] cl_code;
    logic [2:0] wr_code;
    logic       bl_ok;
    logic       cl_ok;
    logic       wr_ok;

    // Slice the raw field codes out of the word.
    always_comb begin
        bl_code = word_i[BL_LSB +: 3];
        cl_code = word_i[CL_LSB +: 3];
        wr_code = word_i[WR_LSB +: 3];
    end

    // Check each field code against its legal set.
    always_comb begin
        bl_ok = (bl_code == 3'b010) || (bl_code == 3'b011);
        cl_ok = (cl_code >= 3'd3) && (cl_code <= 3'd6);
        wr_ok = (wr_code >= 3'd1) && (wr_code <= 3'd5);
    end

    // Produce the decoded fields and the classification of the load.
    always_comb begin
        cfg_o.bl8        = (bl_code == 3'b011);
        cfg_o.interleave = word_i[BT_BIT];
        cfg_o.cas        = cl_code;
        cfg_o.wrec       = wr_code + 3'd1;
        cfg_o.slow_pd    = word_i[PD_BIT];
        is_test_o        = word_i[TM_BIT];
        valid_o          = !word_i[TM_BIT] && bl_ok && cl_ok && wr_ok;
        dll_req_o        = valid_o && word_i[DLL_BIT];
    end

endmodule

// File: rtl/modecfg_store.sv
// Module: modecfg_store
// Holds the accepted configuration, the read-back word and the test flag,
// and produces the one-cycle DLL reset and error pulses. It assumes the
// decode inputs are valid only in cycles where load_i is high.
module modecfg_store
    import modecfg_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  mode_cfg_t         dec_cfg_i,
    input  logic              is_test_i,
    input  logic              valid_i,
    input  logic              dll_req_i,
    output mode_cfg_t         cfg_o,
    output logic [WORD_W-1:0] word_o,
    output logic              test_o,
    output logic              dll_pulse_o,
    output logic              err_o
);

    localparam logic [WORD_W-1:0] WORD_RESET =
        WORD_W'((32'd1 << WR_LSB) | (32'd3 << CL_LSB) | (32'd2 << BL_LSB));

    logic [WORD_W-1:0] word_clr;

    // Clear the DLL bit so that it never reads back as set.
    always_comb begin
        word_clr          = word_i;
        word_clr[DLL_BIT] = 1'b0;
    end

    // Update the configuration and read-back word on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o  <= CFG_RESET;
            word_o <= WORD_RESET;
        end else if (load_i && valid_i) begin
            cfg_o  <= dec_cfg_i;
            word_o <= word_clr;
        end
    end

    // Track test mode: set by a test load, cleared by a valid normal load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_o <= 1'b0;
        end else if (load_i && is_test_i) begin
            test_o <= 1'b1;
        end else if (load_i && valid_i) begin
            test_o <= 1'b0;
        end
    end

    // Generate the single-cycle DLL reset and rejection pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_pulse_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            dll_pulse_o <= load_i && dll_req_i;
            err_o       <= load_i && !valid_i;
        end
    end

endmodule

// File: rtl/modecfg_lockout.sv
// Module: modecfg_lockout
// Counts the read lockout after a DLL reset and gates READ requests.
// A restart during a lockout reloads the full count. Each read is judged
// on the counter value before the edge at which a restart loads.
module modecfg_lockout #(
    parameter int LOCK_CYCLES = 200,
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rd_req_i,
    output logic rd_ok_o,
    output logic rd_grant_o,
    output logic rd_viol_o
);

    logic [CNT_W-1:0] remain;

    // Load the full window on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= CNT_W'(LOCK_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Reads are allowed only once the window has expired.
    always_comb begin
        rd_ok_o    = (remain == '0);
        rd_grant_o = rd_req_i && rd_ok_o;
    end

    // Report a blocked read one cycle after it was refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_viol_o <= 1'b0;
        end else begin
            rd_viol_o <= rd_req_i && !rd_ok_o;
        end
    end

endmodule

// File: rtl/modecfg_ctrl.sv
// Module: modecfg_ctrl (top)
// Mode register programming controller. It decodes LOAD MODE words,
// rejects reserved codes and test requests, holds the accepted fields, and
// applies the read lockout after a DLL reset. It assumes load_i is a
// single-cycle strobe qualified by the command path.
module modecfg_ctrl
    import modecfg_pkg::*;
#(
    parameter int WORD_W      = 14,
    parameter int LOCK_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              rd_req_i,
    output logic              rd_grant_o,
    output logic              rd_ok_o,
    output logic              rd_viol_o,
    output logic              bl8_o,
    output logic              interleave_o,
    output logic [2:0]        cas_lat_o,
    output logic [2:0]        wr_rec_o,
    output logic              slow_pd_o,
    output logic              test_mode_o,
    output logic              dll_rst_o,
    output logic              cfg_err_o,
    output logic [WORD_W-1:0] cfg_word_o
);

    mode_cfg_t dec_cfg;
    mode_cfg_t cur_cfg;
    logic      dec_test;
    logic      dec_valid;
    logic      dec_dll;
    logic      lock_start;

    modecfg_decode #(.WORD_W(WORD_W)) u_decode (
        .word_i    (word_i),
        .cfg_o     (dec_cfg),
        .is_test_o (dec_test),
        .valid_o   (dec_valid),
        .dll_req_o (dec_dll)
    );

    modecfg_store #(.WORD_W(WORD_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .word_i      (word_i),
        .dec_cfg_i   (dec_cfg),
        .is_test_i   (dec_test),
        .valid_i     (dec_valid),
        .dll_req_i   (dec_dll),
        .cfg_o       (cur_cfg),
        .word_o      (cfg_word_o),
        .test_o      (test_mode_o),
        .dll_pulse_o (dll_rst_o),
        .err_o       (cfg_err_o)
    );

    // The lockout starts at the same edge that applies the DLL reset.
    always_comb lock_start = load_i && dec_dll;

    modecfg_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lockout (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (lock_start),
        .rd_req_i   (rd_req_i),
        .rd_ok_o    (rd_ok_o),
        .rd_grant_o (rd_grant_o),
        .rd_viol_o  (rd_viol_o)
    );

    // Fan the held configuration out to the field ports.
    always_comb begin
        bl8_o        = cur_cfg.bl8;
        interleave_o = cur_cfg.interleave;
        cas_lat_o    = cur_cfg.cas;
        wr_rec_o     = cur_cfg.wrec;
        slow_pd_o    = cur_cfg.slow_pd;
    end

endmodule

// File: rtl/modecfg_ctrl_chk.sv
// Module: modecfg_ctrl_chk
// Checker bound to modecfg_ctrl. It observes ports only and relates the
// configuration, pulse and lockout behaviour over time.
module modecfg_ctrl_chk #(
    parameter int WORD_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_i,
    input logic              rd_ok_o,
    input logic              rd_viol_o,
    input logic [2:0]        cas_lat_o,
    input logic [2:0]        wr_rec_o,
    input logic              test_mode_o,
    input logic              dll_rst_o,
    input logic              cfg_err_o,
    input logic [WORD_W-1:0] cfg_word_o
);

    assert_legal_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat_o >= 3'd3) && (cas_lat_o <= 3'd6) &&
        (wr_rec_o >= 3'd2) && (wr_rec_o <= 3'd6));

    assert_reject_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> ($stable(cfg_word_o) && $stable(cas_lat_o) && !dll_rst_o));

    assert_test_flags_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode_o) |-> cfg_err_o);

    assert_dll_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dll_rst_o |-> !rd_ok_o);

    assert_lock_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_ok_o) |-> dll_rst_o);

    assert_blocked_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !rd_ok_o) |=> rd_viol_o);

    assert_no_false_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok_o || !rd_req_i) |=> !rd_viol_o);

endmodule

bind modecfg_ctrl modecfg_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req_i    (rd_req_i),
    .rd_ok_o     (rd_ok_o),
    .rd_viol_o   (rd_viol_o),
    .cas_lat_o   (cas_lat_o),
    .wr_rec_o    (wr_rec_o),
    .test_mode_o (test_mode_o),
    .dll_rst_o   (dll_rst_o),
    .cfg_err_o   (cfg_err_o),
    .cfg_word_o  (cfg_word_o)
);

// File: tb/modecfg_ctrl_test.sv
// Bench for modecfg_ctrl: a vector table of loads, then directed tests.
module modecfg_ctrl_test;

    localparam int WORD_W = 14;
    localparam int LOCK   = 200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [WORD_W-1:0] word_i = '0;
    logic              rd_req_i = 1'b0;
    logic              rd_grant_o, rd_ok_o, rd_viol_o;
    logic              bl8_o, interleave_o, slow_pd_o, test_mode_o;
    logic              dll_rst_o, cfg_err_o;
    logic [2:0]        cas_lat_o, wr_rec_o;
    logic [WORD_W-1:0] cfg_word_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    modecfg_ctrl #(.WORD_W(WORD_W), .LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i),
        .rd_req_i(rd_req_i), .rd_grant_o(rd_grant_o), .rd_ok_o(rd_ok_o),
        .rd_viol_o(rd_viol_o), .bl8_o(bl8_o), .interleave_o(interleave_o),
        .cas_lat_o(cas_lat_o), .wr_rec_o(wr_rec_o), .slow_pd_o(slow_pd_o),
        .test_mode_o(test_mode_o), .dll_rst_o(dll_rst_o),
        .cfg_err_o(cfg_err_o), .cfg_word_o(cfg_word_o)
    );

    // word, err, test, bl8, interleave, cas, wr, pd, read-back word
    typedef struct packed {
        logic [13:0] word;
        logic        err;
        logic        tm;
        logic        bl8;
        logic        il;
        logic [2:0]  cl;
        logic [2:0]  wr;
        logic        pd;
        logic [13:0] rb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{14'h0443, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 3'd3, 1'b0, 14'h0443}, // R2
        '{14'h1A6A, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 3'd6, 1'b1, 14'h1A6A}, // R2 R10
        '{14'h0273, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6, 3'd6, 1'b1, 14'h1A6A}, // R3 CL
        '{14'h0053, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6, 3'd6, 1'b1, 14'h1A6A}, // R3 WR
        '{14'h0231, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6, 3'd6, 1'b1, 14'h1A6A}, // R3 BL
        '{14'h065B, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 3'd4, 1'b0, 14'h065B}, // R2
        '{14'h0F8F, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 3'd4, 1'b0, 14'h065B}, // R4
        '{14'h1832, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 1'b1, 14'h1832}  // R4 R10
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one load for one cycle; returns at the falling edge after it.
    task automatic do_load(input logic [WORD_W-1:0] w, input logic rd);
        @(negedge clk);
        load_i   = 1'b1;
        word_i   = w;
        rd_req_i = rd;
        #1;
        @(negedge clk);
        load_i   = 1'b0;
        rd_req_i = 1'b0;
    endtask

    // Count falling-edge samples with rd_ok low, starting now.
    task automatic count_lock(output int n);
        n = 0;
        while (!rd_ok_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "bl8", 32'(bl8_o), 0);
        check("R1", "interleave", 32'(interleave_o), 0);
        check("R1", "cas", 32'(cas_lat_o), 3);
        check("R1", "wr", 32'(wr_rec_o), 2);
        check("R1", "pd", 32'(slow_pd_o), 0);
        check("R1", "test", 32'(test_mode_o), 0);
        check("R1", "rd_ok", 32'(rd_ok_o), 1);
        check("R1", "word", 32'(cfg_word_o), 32'h0232);

        // R2 R3 R4 R10: vector table
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].word, 1'b0);
            check("R3", "err", 32'(cfg_err_o), 32'(VECS[i].err));
            check("R4", "test", 32'(test_mode_o), 32'(VECS[i].tm));
            check("R2", "bl8", 32'(bl8_o), 32'(VECS[i].bl8));
            check("R2", "interleave", 32'(interleave_o), 32'(VECS[i].il));
            check("R2", "cas", 32'(cas_lat_o), 32'(VECS[i].cl));
            check("R2", "wr", 32'(wr_rec_o), 32'(VECS[i].wr));
            check("R10", "pd", 32'(slow_pd_o), 32'(VECS[i].pd));
            check("R2", "word", 32'(cfg_word_o), 32'(VECS[i].rb));
            check("R5", "no dll pulse", 32'(dll_rst_o), 0);
            @(negedge clk);
            check("R3", "err one cycle", 32'(cfg_err_o), 0);
        end

        // R3: reserved CL with DLL bit set starts no lockout
        do_load(14'h0170, 1'b0);
        check("R3", "err", 32'(cfg_err_o), 1);
        check("R3", "no dll", 32'(dll_rst_o), 0);
        check("R3", "rd_ok", 32'(rd_ok_o), 1);

        // R5 R6: DLL reset pulse, self-clearing read-back, lockout length
        do_load(14'h0543, 1'b0);
        check("R5", "dll pulse", 32'(dll_rst_o), 1);
        check("R5", "word bit8", 32'(cfg_word_o), 32'h0443);
        check("R2", "cas", 32'(cas_lat_o), 4);
        @(negedge clk);
        check("R5", "pulse one cycle", 32'(dll_rst_o), 0);
        count_lock(n);
        check("R6", "lockout length", 32'(n + 1), LOCK);
        check("R6", "rd_ok after", 32'(rd_ok_o), 1);

        // R7: reads allowed outside lockout
        rd_req_i = 1'b1;
        #1;
        check("R7", "grant open", 32'(rd_grant_o), 1);
        @(negedge clk);
        rd_req_i = 1'b0;
        check("R7", "no viol open", 32'(rd_viol_o), 0);

        // R9: same-cycle read and DLL load, read judged before the load
        do_load(14'h0543, 1'b1);
        check("R9", "lock started", 32'(rd_ok_o), 0);
        check("R9", "no viol", 32'(rd_viol_o), 0);

        // R7: read during lockout is refused and flagged
        rd_req_i = 1'b1;
        #1;
        check("R7", "grant blocked", 32'(rd_grant_o), 0);
        @(negedge clk);
        rd_req_i = 1'b0;
        check("R7", "viol", 32'(rd_viol_o), 1);
        @(negedge clk);
        check("R7", "viol one cycle", 32'(rd_viol_o), 0);

        // R8 R9: restart mid-lockout with a read in the same cycle
        repeat (50) @(negedge clk);
        do_load(14'h0543, 1'b1);
        check("R9", "viol on locked read", 32'(rd_viol_o), 1);
        count_lock(n);
        check("R8", "restart length", 32'(n), LOCK);
        check("R8", "rd_ok after", 32'(rd_ok_o), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule